// File: doc/BRIEF.md
# Bidirectional I/O Port with Latch and Pin Readback

This block is an 8-bit general-purpose I/O port that sits on a simple register bus. Every bit has its own direction control. A bit set as an output drives the stored output latch onto its pad. A bit set as an input turns off that pad's driver. The pad is modelled as three separate vectors: output-enable, output value and input value.

Software reads the port in one of two ways. A read of the latch address returns the value stored in the output latch. A read of the port address returns the levels seen on the pins, after a two-flop synchroniser. Writes to either of these addresses load the same latch. Two more addresses set or clear single latch bits, so software can change one bit without a read-modify-write.

This split matters for read-modify-write code. If the read goes through the port address, the levels on input pins, or on pins forced low from outside, are copied into the latch. If the read goes through the latch address, this cannot happen.

Top module: `gpio_port_rb`

## Requirements
- R1: After reset the direction register holds all ones, the output latch holds 0x00, `pad_oe` is 0x00 and `bus_rdata` is 0x00.
- R2: Each bit of `pad_oe` is the inverse of the matching direction bit, and `pad_out` always equals the output latch. Both update in the cycle after the write that changes them.
- R3: A write to offset 1 (port) or to offset 2 (latch) stores the whole data byte into the output latch. The two addresses have exactly the same write effect.
- R4: A read at offset 2 returns the output latch, whatever levels are present on the pins.
- R5: A read at offset 1 returns `pad_in` after a two-flop synchroniser, not the latch. A pin change that happens before clock edge e is seen by a read that is sampled at edge e+2 or later.
- R6: A write to offset 3 sets every latch bit that is 1 in the data. A write to offset 4 clears every latch bit that is 1 in the data. All other latch bits keep their value. Reads at offsets 3 and 4 return the latch.
- R7: `bus_rdata` is registered. It loads at the clock edge that samples `bus_rd` and holds its value until the next read. A read and a write in the same cycle return the value from before the write.
- R8: Offsets 5 to 7 are unmapped. A write there changes neither the direction register nor the latch, and a read there returns 0x00.
- R9: Offset 0 holds the direction register for both read and write. A bit value of 1 means input and 0 means output.
- R10: A read-modify-write done through offset 2 never copies input-pin levels into the latch. The same sequence done through offset 1 copies the input pin levels into the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_oe | output | 8 | Per-bit pad driver enable (1 = drive) |
| pad_out | output | 8 | Per-bit pad output value |
| pad_in | input | 8 | Per-bit level seen at the pad |

## Verification
A register read and a register write can fall in the same clock cycle, and the read must return the value from before the write. The bench provokes this by raising both strobes on the latch offset in one cycle. The scoreboard expects the old latch value in the read data, and a later plain read must return the new value. A second overlap is between a pin change and a port read. The bench holds off its port reads until the synchroniser has settled, and it also compares a latch read against a port read while a pin is forced against the driven latch value.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;

    localparam int unsigned RB_ADDR_W = 3;

    typedef enum logic [RB_ADDR_W-1:0] {
        RB_DIR   = 3'd0,
        RB_PORT  = 3'd1,
        RB_LATCH = 3'd2,
        RB_SET   = 3'd3,
        RB_CLR   = 3'd4
    } rb_addr_e;

    function automatic logic rb_is_latch_write(input logic [RB_ADDR_W-1:0] a);
        return (a == RB_PORT) || (a == RB_LATCH);
    endfunction

endpackage

// File: rtl/gpio_rb_sync.sv
module gpio_rb_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_chain
        always_comb begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_out = stage_q[LAST];
endmodule

// File: rtl/gpio_rb_regs.sv
module gpio_rb_regs
    import gpio_rb_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RB_ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]     wr_data,
    output logic [WIDTH-1:0]     dir_o,
    output logic [WIDTH-1:0]     lat_o
);
    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] lat;
    } regs_t;

    localparam regs_t REGS_RST = '{dir: {WIDTH{1'b1}}, lat: '0};

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (rb_is_latch_write(wr_addr)) begin
                regs_d.lat = wr_data;
            end else begin
                case (rb_addr_e'(wr_addr))
                    RB_DIR:  regs_d.dir = wr_data;
                    RB_SET:  regs_d.lat = regs_q.lat | wr_data;
                    RB_CLR:  regs_d.lat = regs_q.lat & ~wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dir_o = regs_q.dir;
    assign lat_o = regs_q.lat;
endmodule

// File: rtl/gpio_rb_rdmux.sv
module gpio_rb_rdmux
    import gpio_rb_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [RB_ADDR_W-1:0] rd_addr,
    input  logic [WIDTH-1:0]     dir_i,
    input  logic [WIDTH-1:0]     lat_i,
    input  logic [WIDTH-1:0]     pins_i,
    output logic [WIDTH-1:0]     rdata_o
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [WIDTH-1:0] sel;

    always_comb begin
        case (rb_addr_e'(rd_addr))
            RB_DIR:                   sel = dir_i;
            RB_PORT:                  sel = pins_i;
            RB_LATCH, RB_SET, RB_CLR: sel = lat_i;
            default:                  sel = '0;
        endcase
        rd_d = rd_q;
        if (rd_en) begin
            rd_d.data = sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o = rd_q.data;
endmodule

// File: rtl/gpio_port_rb.sv
module gpio_port_rb
    import gpio_rb_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [RB_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]     bus_wdata,
    output logic [WIDTH-1:0]     bus_rdata,
    output logic [WIDTH-1:0]     pad_oe,
    output logic [WIDTH-1:0]     pad_out,
    input  logic [WIDTH-1:0]     pad_in
);
    logic [WIDTH-1:0] dir_w, lat_w, pins_w;

    gpio_rb_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pins_w)
    );

    gpio_rb_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .dir_o   (dir_w),
        .lat_o   (lat_w)
    );

    gpio_rb_rdmux #(.WIDTH(WIDTH)) u_rdmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (bus_rd),
        .rd_addr (bus_addr),
        .dir_i   (dir_w),
        .lat_i   (lat_w),
        .pins_i  (pins_w),
        .rdata_o (bus_rdata)
    );

    for (genvar b = 0; b < WIDTH; b++) begin : g_pad
        assign pad_oe[b]  = ~dir_w[b];
        assign pad_out[b] = lat_w[b];
    end
endmodule

// File: rtl/gpio_rb_chk.sv
module gpio_rb_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [2:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_out
);
    p_dir_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0) |=> (pad_oe == ~$past(bus_wdata)));

    p_alias_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 3'd1 || bus_addr == 3'd2)) |=> (pad_out == $past(bus_wdata)));

    p_latch_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd2) |=> (bus_rdata == $past(pad_out)));

    p_set_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd3) |=> (pad_out == ($past(pad_out) | $past(bus_wdata))));

    p_clr_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd4) |=> (pad_out == ($past(pad_out) & ~$past(bus_wdata))));

    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    p_unmapped_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr >= 3'd5) |=> (bus_rdata == '0));

    p_unmapped_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= 3'd5) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_port_rb gpio_rb_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
);

// File: tb/tb_gpio_port_rb.sv
module tb_gpio_port_rb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, pad_oe, pad_out, pad_in;

    logic [7:0] ext_lvl = 8'h00, short_en = 8'h00, short_val = 8'h00;
    logic [7:0] m_dir = 8'hFF, m_lat = 8'h00;
    int errors = 0, checks = 0;
    bit done = 0;

    typedef struct { logic [7:0] exp; string tag; } item_t;
    item_t sb_q[$];
    logic rd_seen = 1'b0;

    always #10 clk = ~clk;

    assign pad_in = (short_en & short_val) |
                    (~short_en & ((pad_oe & pad_out) | (~pad_oe & ext_lvl)));

    gpio_port_rb dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_in(pad_in)
    );

    function automatic logic [7:0] model_pins();
        return (short_en & short_val) |
               (~short_en & ((~m_dir & m_lat) | (m_dir & ext_lvl)));
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data one cycle after the read strobe
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, bus_rdata, it.exp);
        end
    end

    task automatic model_write(input logic [2:0] a, input logic [7:0] d);
        case (a)
            3'd0: m_dir = d;
            3'd1, 3'd2: m_lat = d;
            3'd3: m_lat = m_lat | d;
            3'd4: m_lat = m_lat & ~d;
            default: ;
        endcase
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        sb_q.push_back('{exp, tag});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
        rst_n = 1'b1;
        bus_read(3'd0, 8'hFF, "R1 dir reset");
        bus_read(3'd2, 8'h00, "R1 latch reset");

        // R9 / R2 direction and drive
        bus_write(3'd0, 8'h0F);
        bus_read(3'd0, 8'h0F, "R9 dir readback");
        check("R2 pad_oe", pad_oe, 8'hF0);
        bus_write(3'd2, 8'h5A);
        check("R2 pad_out", pad_out, 8'h5A);

        // R3 port write aliases latch
        bus_write(3'd1, 8'hC3);
        bus_read(3'd2, 8'hC3, "R3 port write lands in latch");

        // R4 / R5 inputs differ from latch
        ext_lvl = 8'h3C;
        settle();
        bus_read(3'd2, 8'hC3, "R4 latch read ignores pins");
        bus_read(3'd1, model_pins(), "R5 port read shows pins");

        // R5 synchroniser latency: change then read immediately sees old
        rv = model_pins();
        @(negedge clk);
        ext_lvl = 8'hA5;
        bus_rd = 1'b1; bus_addr = 3'd1;
        sb_q.push_back('{rv, "R5 sync latency old value"});
        @(negedge clk);
        bus_rd = 1'b0;
        settle();
        bus_read(3'd1, model_pins(), "R5 settled new value");

        // R4 shorted output pin
        bus_write(3'd0, 8'h00);
        bus_write(3'd2, 8'hFF);
        short_en = 8'h01; short_val = 8'h00;
        settle();
        bus_read(3'd1, 8'hFE, "R4 forced pin on port read");
        bus_read(3'd2, 8'hFF, "R4 latch unaffected by forced pin");
        short_en = 8'h00;

        // R6 set / clear
        bus_write(3'd2, 8'h0F);
        bus_write(3'd3, 8'h30);
        bus_read(3'd3, 8'h3F, "R6 set bits");
        bus_write(3'd4, 8'h05);
        bus_read(3'd4, 8'h3A, "R6 clear bits");
        check("R6 pad_out", pad_out, 8'h3A);

        // R7 same-cycle read and write
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h99;
        sb_q.push_back('{m_lat, "R7 read before write"});
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        model_write(3'd2, 8'h99);
        repeat (2) @(negedge clk);
        check("R7 rdata holds", bus_rdata, 8'h3A);
        bus_read(3'd2, 8'h99, "R7 new value after write");

        // R8 unmapped
        bus_write(3'd6, 8'h11);
        bus_write(3'd5, 8'h22);
        bus_read(3'd2, 8'h99, "R8 latch unchanged");
        bus_read(3'd0, 8'h00, "R8 dir unchanged");
        bus_read(3'd7, 8'h00, "R8 unmapped read zero");

        // R10 read-modify-write hazard
        bus_write(3'd0, 8'hF0);
        bus_write(3'd2, 8'h00);
        ext_lvl = 8'hA0;
        settle();
        rv = model_pins();
        bus_read(3'd1, 8'hA0, "R10 port read of inputs");
        bus_write(3'd1, rv | 8'h01);
        bus_read(3'd2, 8'hA1, "R10 port RMW copies inputs");
        bus_write(3'd2, 8'h00);
        bus_read(3'd2, 8'h00, "R10 latch read for RMW");
        bus_write(3'd2, 8'h00 | 8'h01);
        bus_read(3'd2, 8'h01, "R10 latch RMW keeps inputs out");
        check("R10 pad_out", pad_out, 8'h01);

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            errors++; checks++;
            $display("FAIL scoreboard: actual=%0d expected=0 pending", sb_q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule